// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and Transceiver Control

This block joins a processor whose low address and data share pins to a conventional system bus. The system bus has a separate address and an 8-bit data path. The processor-side inputs are:

- eight shared low address/data lines;
- eight dedicated upper address lines;
- four upper lines that carry address early in the cycle and status later;
- the control signals address strobe, data enable, direction, I/O-or-memory select, read and write.

The block captures a 20-bit address while the address strobe is high and keeps it steady once the strobe drops. After that drop the shared lines can carry data and the top lines can carry status without disturbing the address. It steers the 8-bit data path in one direction at a time. Each side has its own drive-enable output in place of internal tristate nets, so the pad ring or the next block does the actual tristating. It also decodes separate active-low read and write strobes for memory space and for I/O space.

Asynchronous reset clears the held address. It disables both data drivers and deasserts every strobe. The block stays quiet for two clock edges after reset release, until the synchronised reset lets it run.

Top module: `mux_bus_demux`

## Requirements
- R1: The address output is assembled as bits [19:16] from the four top address/status lines, bits [15:8] from the dedicated upper lines and bits [7:0] from the shared low lines.
- R2: While the address strobe is high, the address output follows the inputs in the same cycle, and the value present at each rising clock edge is captured.
- R3: While the address strobe is low, the address output holds the value captured at the last rising edge with the strobe high, whatever the address inputs do.
- R4: With data enable high (inactive), neither data drive-enable is asserted and both data outputs read zero.
- R5: With data enable low and direction high, the system-side drive-enable is 1 and the system data output equals the shared low lines; the processor-side enable is 0.
- R6: With data enable low and direction low, the processor-side drive-enable is 1 and the processor data output equals the system data input; the system-side enable is 0. A change of direction takes effect without waiting for a clock.
- R7: The memory read strobe is low exactly when read is low and I/O-or-memory select is low. The memory write strobe is low exactly when write is low and that select is low.
- R8: The I/O read strobe is low exactly when read is low and the select is high. The I/O write strobe is low exactly when write is low and the select is high.
- R9: While reset is low, the address reads zero (strobe low), both drive-enables are 0 and all four strobes are high. After release this persists through the first rising clock edge and ends at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_lo_i | input | 8 | Shared low address/data lines from the processor |
| ad_lo_o | output | 8 | Data toward the processor on the shared lines |
| ad_lo_oe | output | 1 | Drive enable for the processor side |
| a_mid_i | input | 8 | Dedicated upper address lines |
| as_hi_i | input | 4 | Top address/status lines |
| ale_i | input | 1 | Address strobe, high while address is valid |
| den_n_i | input | 1 | Data enable, active low |
| dtr_n_i | input | 1 | Direction: high toward system, low toward processor |
| iom_n_i | input | 1 | Target select: high I/O, low memory |
| rd_n_i | input | 1 | Read, active low |
| wr_n_i | input | 1 | Write, active low |
| addr_o | output | 20 | Latched system address |
| sd_i | input | 8 | System data input |
| sd_o | output | 8 | System data output |
| sd_oe | output | 1 | Drive enable for the system side |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| io_rd_n_o | output | 1 | I/O read strobe, active low |
| io_wr_n_o | output | 1 | I/O write strobe, active low |

## Verification
A table of bus cycles drives the block through the following cycles, each an address phase and then a data phase:

- a memory read;
- an I/O write;
- an idle data phase;
- a memory write;
- an I/O read.

Distinct byte patterns in each address group catch swapped or shifted fields. Status and data values placed on the same pins during the data phase separate a true hold from a latch that stays open. Opposite direction settings under one enable show whether the enables or data steering are crossed. Both settings of the select line show whether memory and I/O strobes leak into each other. Directed steps apply reset in the middle of a data phase, count the two edges of the release, and flip direction without a clock edge.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  localparam int unsigned LO_W_DEF  = 8;
  localparam int unsigned MID_W_DEF = 8;
  localparam int unsigned HI_W_DEF  = 4;
  localparam int unsigned SYNC_DEF  = 2;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } strobe_t;

endpackage

// File: rtl/mux_bus_rst_sync.sv
module mux_bus_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run_o = sync_q[STAGES-1];

endmodule

// File: rtl/mux_bus_addr_latch.sv
module mux_bus_addr_latch #(
  parameter int unsigned LO_W  = 8,
  parameter int unsigned MID_W = 8,
  parameter int unsigned HI_W  = 4,
  localparam int unsigned ADDR_W = LO_W + MID_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ale,
  input  logic [LO_W-1:0]   lo,
  input  logic [MID_W-1:0]  mid,
  input  logic [HI_W-1:0]   hi,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] live;
  logic [ADDR_W-1:0] hold_q;
  logic [ADDR_W-1:0] hold_d;
  logic              open_en;

  assign live    = {hi, mid, lo};
  assign open_en = run & ale;

  always_comb begin
    hold_d = hold_q;
    if (open_en) hold_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign addr = open_en ? live : hold_q;

endmodule

// File: rtl/mux_bus_xcvr_ctl.sv
module mux_bus_xcvr_ctl #(
  parameter int unsigned DW = 8
) (
  input  logic          run,
  input  logic          den_n,
  input  logic          dtr_n,
  input  logic [DW-1:0] proc_in,
  input  logic [DW-1:0] sys_in,
  output logic [DW-1:0] sys_out,
  output logic          sys_oe,
  output logic [DW-1:0] proc_out,
  output logic          proc_oe
);

  logic active;

  always_comb begin
    active   = run & ~den_n;
    sys_oe   = active & dtr_n;
    proc_oe  = active & ~dtr_n;
    sys_out  = sys_oe  ? proc_in : '0;
    proc_out = proc_oe ? sys_in  : '0;
  end

endmodule

// File: rtl/mux_bus_strobe_dec.sv
module mux_bus_strobe_dec
  import mux_bus_pkg::*;
(
  input  logic    run,
  input  logic    iom_n,
  input  logic    rd_n,
  input  logic    wr_n,
  output strobe_t stb
);

  logic rd, wr;

  always_comb begin
    rd         = run & ~rd_n;
    wr         = run & ~wr_n;
    stb.mem_rd = rd & ~iom_n;
    stb.mem_wr = wr & ~iom_n;
    stb.io_rd  = rd &  iom_n;
    stb.io_wr  = wr &  iom_n;
  end

endmodule

// File: rtl/mux_bus_demux.sv
module mux_bus_demux
  import mux_bus_pkg::*;
#(
  parameter int unsigned LO_W   = LO_W_DEF,
  parameter int unsigned MID_W  = MID_W_DEF,
  parameter int unsigned HI_W   = HI_W_DEF,
  parameter int unsigned STAGES = SYNC_DEF,
  localparam int unsigned ADDR_W = LO_W + MID_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LO_W-1:0]   ad_lo_i,
  output logic [LO_W-1:0]   ad_lo_o,
  output logic              ad_lo_oe,
  input  logic [MID_W-1:0]  a_mid_i,
  input  logic [HI_W-1:0]   as_hi_i,
  input  logic              ale_i,
  input  logic              den_n_i,
  input  logic              dtr_n_i,
  input  logic              iom_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [LO_W-1:0]   sd_i,
  output logic [LO_W-1:0]   sd_o,
  output logic              sd_oe,
  output logic              mem_rd_n_o,
  output logic              mem_wr_n_o,
  output logic              io_rd_n_o,
  output logic              io_wr_n_o
);

  logic    run_q;
  strobe_t stb;

  mux_bus_rst_sync #(.STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run_o (run_q)
  );

  mux_bus_addr_latch #(.LO_W(LO_W), .MID_W(MID_W), .HI_W(HI_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .ale   (ale_i),
    .lo    (ad_lo_i),
    .mid   (a_mid_i),
    .hi    (as_hi_i),
    .addr  (addr_o)
  );

  mux_bus_xcvr_ctl #(.DW(LO_W)) u_xcvr (
    .run      (run_q),
    .den_n    (den_n_i),
    .dtr_n    (dtr_n_i),
    .proc_in  (ad_lo_i),
    .sys_in   (sd_i),
    .sys_out  (sd_o),
    .sys_oe   (sd_oe),
    .proc_out (ad_lo_o),
    .proc_oe  (ad_lo_oe)
  );

  mux_bus_strobe_dec u_dec (
    .run   (run_q),
    .iom_n (iom_n_i),
    .rd_n  (rd_n_i),
    .wr_n  (wr_n_i),
    .stb   (stb)
  );

  assign mem_rd_n_o = ~stb.mem_rd;
  assign mem_wr_n_o = ~stb.mem_wr;
  assign io_rd_n_o  = ~stb.io_rd;
  assign io_wr_n_o  = ~stb.io_wr;

endmodule

// File: rtl/mux_bus_demux_chk.sv
module mux_bus_demux_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              ale_i,
  input logic [7:0]        ad_lo_i,
  input logic [7:0]        a_mid_i,
  input logic [3:0]        as_hi_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              den_n_i,
  input logic              iom_n_i,
  input logic              sd_oe,
  input logic              ad_lo_oe,
  input logic              mem_rd_n_o,
  input logic              mem_wr_n_o,
  input logic              io_rd_n_o,
  input logic              io_wr_n_o
);

  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_i && run_q) |-> addr_o == {as_hi_i, a_mid_i, ad_lo_i});

  a_r3_capture_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale_i) && $past(run_q)) |-> addr_o == $past({as_hi_i, a_mid_i, ad_lo_i}));

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_i && $past(!ale_i) && run_q && $past(run_q)) |-> $stable(addr_o));

  a_r4_den_off: assert property (@(posedge clk) disable iff (!rst_n)
    den_n_i |-> (!sd_oe && !ad_lo_oe));

  a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sd_oe, ad_lo_oe}));

  a_r7_mem_space: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n_o || !mem_wr_n_o) |-> !iom_n_i);

  a_r8_io_space: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd_n_o || !io_wr_n_o) |-> iom_n_i);

  a_r8_read_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~mem_rd_n_o, ~io_rd_n_o}));

endmodule

bind mux_bus_demux mux_bus_demux_chk #(.ADDR_W(20)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_q      (run_q),
  .ale_i      (ale_i),
  .ad_lo_i    (ad_lo_i),
  .a_mid_i    (a_mid_i),
  .as_hi_i    (as_hi_i),
  .addr_o     (addr_o),
  .den_n_i    (den_n_i),
  .iom_n_i    (iom_n_i),
  .sd_oe      (sd_oe),
  .ad_lo_oe   (ad_lo_oe),
  .mem_rd_n_o (mem_rd_n_o),
  .mem_wr_n_o (mem_wr_n_o),
  .io_rd_n_o  (io_rd_n_o),
  .io_wr_n_o  (io_wr_n_o)
);

// File: tb/sim_mux_bus_demux.sv
`timescale 1ns/1ps
module sim_mux_bus_demux;

  logic        clk;
  logic        rst_n;
  logic [7:0]  ad_lo_i, ad_lo_o, a_mid_i, sd_i, sd_o;
  logic [3:0]  as_hi_i;
  logic        ad_lo_oe, sd_oe;
  logic        ale_i, den_n_i, dtr_n_i, iom_n_i, rd_n_i, wr_n_i;
  logic [19:0] addr_o;
  logic        mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o;

  int unsigned n_chk;
  int unsigned n_bad;

  mux_bus_demux u0 (
    .clk(clk), .rst_n(rst_n),
    .ad_lo_i(ad_lo_i), .ad_lo_o(ad_lo_o), .ad_lo_oe(ad_lo_oe),
    .a_mid_i(a_mid_i), .as_hi_i(as_hi_i), .ale_i(ale_i),
    .den_n_i(den_n_i), .dtr_n_i(dtr_n_i), .iom_n_i(iom_n_i),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .addr_o(addr_o),
    .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe),
    .mem_rd_n_o(mem_rd_n_o), .mem_wr_n_o(mem_wr_n_o),
    .io_rd_n_o(io_rd_n_o), .io_wr_n_o(io_wr_n_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {ale, den_n, dtr_n, iom_n, rd_n, wr_n, hi[3:0], mid[7:0], lo[7:0], sd[7:0]}
  localparam logic [33:0] VEC [8] = '{
    {6'b1_1_1_0_1_1, 4'h9, 8'h12, 8'h34, 8'h00},
    {6'b0_0_0_0_0_1, 4'h5, 8'h12, 8'hA5, 8'h5A},
    {6'b1_1_1_1_1_1, 4'h0, 8'h00, 8'h60, 8'h00},
    {6'b0_0_1_1_1_0, 4'hF, 8'h00, 8'hC3, 8'h00},
    {6'b0_1_1_1_1_1, 4'h3, 8'hFF, 8'h11, 8'h22},
    {6'b1_1_1_0_1_1, 4'hA, 8'hBC, 8'hDE, 8'h00},
    {6'b0_0_1_0_1_0, 4'h4, 8'hBC, 8'h77, 8'h00},
    {6'b0_0_0_1_0_1, 4'h6, 8'h55, 8'h99, 8'h81}
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [33:0] v);
    {ale_i, den_n_i, dtr_n_i, iom_n_i, rd_n_i, wr_n_i,
     as_hi_i, a_mid_i, ad_lo_i, sd_i} = v;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [19:0] mdl_addr;
    logic        e_soe, e_poe;
    logic [3:0]  e_stb;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b1;
    drive({6'b0_0_1_0_0_0, 4'hF, 8'hFF, 8'hFF, 8'hFF});
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state even with enable, read and write active
    check(addr_o == 20'h0, "R9 addr in reset", 32'(addr_o), 0);
    check(!sd_oe && !ad_lo_oe, "R9 enables in reset", {sd_oe, ad_lo_oe}, 0);
    check({mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o} == 4'hF, "R9 strobes in reset",
          {mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o}, 4'hF);
    @(negedge clk);
    drive({6'b0_1_1_1_1_1, 4'h0, 8'h00, 8'h00, 8'h00});
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    mdl_addr = 20'h0;
    for (int i = 0; i < 8; i++) begin
      logic [33:0] v;
      logic        ale, den_n, dtr_n, iom_n, rd_n, wr_n;
      logic [3:0]  hi;
      logic [7:0]  mid, lo, sd;
      v = VEC[i];
      {ale, den_n, dtr_n, iom_n, rd_n, wr_n, hi, mid, lo, sd} = v;
      @(negedge clk);
      drive(v);
      @(posedge clk);
      #1;
      if (ale) mdl_addr = {hi, mid, lo};
      check(addr_o == mdl_addr, ale ? "R1/R2 address open" : "R3 address held",
            32'(addr_o), 32'(mdl_addr));
      e_soe = !den_n && dtr_n;
      e_poe = !den_n && !dtr_n;
      check(sd_oe == e_soe && ad_lo_oe == e_poe, den_n ? "R4 enables off" : "R5/R6 enables",
            {sd_oe, ad_lo_oe}, {e_soe, e_poe});
      check(sd_o == (e_soe ? lo : 8'h00), "R5 system data", 32'(sd_o), 32'(e_soe ? lo : 8'h00));
      check(ad_lo_o == (e_poe ? sd : 8'h00), "R6 processor data",
            32'(ad_lo_o), 32'(e_poe ? sd : 8'h00));
      e_stb = {~(!rd_n && !iom_n), ~(!wr_n && !iom_n), ~(!rd_n && iom_n), ~(!wr_n && iom_n)};
      check({mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o} == e_stb, "R7/R8 strobes",
            {mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o}, 32'(e_stb));
    end

    // R3: address inputs swing widely with strobe low, address unchanged
    @(negedge clk);
    drive({6'b0_1_1_1_1_1, 4'h0, 8'h00, 8'h00, 8'h00});
    @(posedge clk);
    #1;
    check(addr_o == 20'hABCDE, "R3 hold with inputs zero", 32'(addr_o), 32'h000ABCDE);

    // R6: direction flip without a clock edge
    @(negedge clk);
    drive({6'b0_0_1_0_1_1, 4'h0, 8'h00, 8'h3C, 8'hE1});
    #1;
    check(sd_oe && !ad_lo_oe && sd_o == 8'h3C, "R5 toward system",
          {sd_oe, ad_lo_oe, sd_o}, {2'b10, 8'h3C});
    dtr_n_i = 1'b0;
    #1;
    check(!sd_oe && ad_lo_oe && ad_lo_o == 8'hE1, "R6 flip same cycle",
          {sd_oe, ad_lo_oe, ad_lo_o}, {2'b01, 8'hE1});

    // R9: asynchronous reset in a data phase, then two-edge release
    @(negedge clk);
    drive({6'b0_0_1_0_0_1, 4'h1, 8'h23, 8'h45, 8'h00});
    rst_n = 1'b0;
    #1;
    check(addr_o == 20'h0, "R9 async clear", 32'(addr_o), 0);
    check(!sd_oe && mem_rd_n_o, "R9 async disable", {sd_oe, mem_rd_n_o}, 32'b01);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(!sd_oe && mem_rd_n_o, "R9 quiet after first edge", {sd_oe, mem_rd_n_o}, 32'b01);
    @(posedge clk);
    #1;
    check(sd_oe && !mem_rd_n_o, "R9 running after second edge", {sd_oe, mem_rd_n_o}, 32'b10);
    check(addr_o == 20'h0, "R9 address still zero", 32'(addr_o), 0);

    finish_run();
  end

endmodule